// File: doc/BRIEF.md
# Descriptor-driven multi-channel copy engine

This block moves words from one memory region to another under the control of descriptors held in memory. Four independent channels share one word-wide memory master port. Each channel owns a command pointer, a semaphore count and an error status. Software builds a descriptor chain, points a channel at it and adds to the channel's semaphore. From then on the engine fetches descriptors, copies the data they describe, marks each one done in memory and follows the links.

There is no start bit. Writing to a semaphore adds to its count, and a channel runs whenever it is enabled, its count is nonzero and its error status is clear. Two control flags in each descriptor decide what happens when that descriptor completes: one lowers the semaphore by one, the other raises the channel's interrupt flag. The semaphore therefore sets how many descriptors of a chain are processed before the channel waits for software. When several channels are ready at once, they take turns one descriptor at a time.

Top module: `desc_copy_engine`

## Requirements
- R1: After reset every readable register returns 0, irq is low and mem_req is low.
- R2: Each channel n has a register group at 0x100 + 0x40*n: command pointer at +0x00 (read/write), semaphore at +0x10, error status at +0x20 and its clear alias at +0x28. A write to the semaphore adds wdata[7:0] to the 8-bit count, modulo 256. A read of the semaphore returns the count.
- R3: A channel starts a descriptor only when three conditions hold: its bit in the enable mask (register 0x20, bits 7:0, read/write) is set, its count is nonzero, and its error status is zero. A channel that does not meet them makes no memory access.
- R4: A descriptor is read at the command pointer as words 0..5, in ascending address order. Word 0 is the next-descriptor address, word 1 is control, word 3 is the source, word 4 is the destination and word 5 is the byte size. The engine copies size/4 words in ascending order. A size of 0 copies nothing, and the word just past the destination range is left untouched.
- R5: On success the engine writes 0 to descriptor word 7 (pointer + 0x1C). If control bit 0 is set, it then sets bit n of the global flag register at 0x10. irq is high while any flag is set.
- R6: When control bit 1 is set, a successful completion lowers the channel's semaphore by one.
- R7: On completion with a nonzero next address, the command pointer takes that address, and processing continues only if the count is still nonzero. With a zero next address, the count is cleared and the command pointer is kept.
- R8: A memory error response sets status code 1. A size whose bits 1:0 are not zero sets status code 2. In either case the channel's flag is raised whatever control bit 0 says, no status word is written and the count is left unchanged. The channel stays stopped while its code is nonzero.
- R9: Writing ones to 0x18 clears exactly those global flag bits. Writing ones to a channel's +0x28 clears exactly those status bits.
- R10: Ready channels are served round-robin, one descriptor per turn. The search starts after the last channel served, and after reset channel 0 comes first.
- R11: mem_req, mem_addr and mem_we hold steady until mem_ack. mem_err is sampled with mem_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 32 | Memory write data |
| mem_ack | input | 1 | Memory access completed |
| mem_rdata | input | 32 | Memory read data, valid with mem_ack |
| mem_err | input | 1 | Memory error response, valid with mem_ack |
| irq | output | 1 | OR of the per-channel flags |

## Verification
The hardest state to reach is the one where several channels become ready in the same cycle, each with a chain in flight. Without it, the round-robin rotation cannot be told apart from fixed priority. The bench loads the pointer and semaphore of three channels while the enable mask is still zero, then opens all three with a single mask write. It then logs the address of every descriptor fetch and compares the interleaving. A second situation that is hard to reach is a chain that stops part-way because its count ran out. The bench creates it with a one-count semaphore and a decrementing first link, then adds one more count and checks that the engine resumes at the stored link.

// File: rtl/desc_copy_engine.sv
module desc_copy_engine #(
  parameter int NCH  = 4,
  parameter int SEMW = 8,
  parameter int ERRW = 8,
  parameter int ENW  = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [11:0] reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        mem_req,
  output logic        mem_we,
  output logic [31:0] mem_addr,
  output logic [31:0] mem_wdata,
  input  logic        mem_ack,
  input  logic [31:0] mem_rdata,
  input  logic        mem_err,
  output logic        irq
);
  localparam int CW = (NCH > 1) ? $clog2(NCH) : 1;
  localparam logic [11:0] A_FLAG = 12'h010;
  localparam logic [11:0] A_FCLR = 12'h018;
  localparam logic [11:0] A_MASK = 12'h020;
  localparam logic [11:0] A_GRP  = 12'h100;
  localparam logic [11:0] A_END  = A_GRP + 12'(NCH * 64);
  localparam logic [ERRW-1:0] E_BUS  = ERRW'(1);
  localparam logic [ERRW-1:0] E_SIZE = ERRW'(2);

  typedef enum logic [2:0] {S_IDLE, S_FETCH, S_RD, S_WR, S_WB} st_t;

  st_t            state;
  logic [CW-1:0]  cur, last, pick;
  logic [2:0]     widx;
  logic [31:0]    d_base, d_next, d_src, d_dst, d_size, hold;
  logic [1:0]     d_ctl;

  logic [31:0]    cmdptr [NCH];
  logic [SEMW-1:0] sema  [NCH];
  logic [ERRW-1:0] cst   [NCH];
  logic [NCH-1:0] gflag;
  logic [ENW-1:0] chen;

  logic           in_grp;
  logic [CW-1:0]  gch;
  logic [5:0]     goff;
  logic [NCH-1:0] ready, own, wr_cmd, wr_sem, wr_clr;
  logic           found, acc, fault, badsz, err_ev, done;
  logic [ERRW-1:0] err_code;

  assign in_grp = (reg_addr >= A_GRP) && (reg_addr < A_END);
  assign gch    = CW'((reg_addr - A_GRP) >> 6);
  assign goff   = reg_addr[5:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ready[c]  = chen[c] && (sema[c] != '0) && (cst[c] == '0);
    assign own[c]    = (cur == CW'(c));
    assign wr_cmd[c] = reg_wr && in_grp && (gch == CW'(c)) && (goff == 6'h00);
    assign wr_sem[c] = reg_wr && in_grp && (gch == CW'(c)) && (goff == 6'h10);
    assign wr_clr[c] = reg_wr && in_grp && (gch == CW'(c)) && (goff == 6'h28);
  end

  always_comb begin
    found = 1'b0;
    pick  = '0;
    for (int k = 1; k <= NCH; k++) begin
      int j;
      j = (int'(last) + k) % NCH;
      if (!found && ready[j]) begin
        found = 1'b1;
        pick  = CW'(j);
      end
    end
  end

  assign acc      = mem_req && mem_ack;
  assign fault    = acc && mem_err;
  assign badsz    = acc && !mem_err && (state == S_FETCH) && (widx == 3'd5) && (mem_rdata[1:0] != 2'b00);
  assign err_ev   = fault || badsz;
  assign err_code = fault ? E_BUS : E_SIZE;
  assign done     = acc && !mem_err && (state == S_WB);

  assign mem_req   = (state != S_IDLE);
  assign mem_we    = (state == S_WR) || (state == S_WB);
  assign mem_addr  = (state == S_FETCH) ? d_base + {27'd0, widx, 2'b00} :
                     (state == S_RD)    ? d_src :
                     (state == S_WR)    ? d_dst :
                     (state == S_WB)    ? d_base + 32'h1C : 32'h0;
  assign mem_wdata = (state == S_WR) ? hold : 32'h0;
  assign irq       = |gflag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cur    <= '0;
      last   <= CW'(NCH - 1);
      widx   <= '0;
      d_base <= '0;
      d_next <= '0;
      d_ctl  <= '0;
      d_src  <= '0;
      d_dst  <= '0;
      d_size <= '0;
      hold   <= '0;
    end else begin
      case (state)
        S_IDLE: if (found) begin
          cur    <= pick;
          last   <= pick;
          d_base <= cmdptr[pick];
          widx   <= '0;
          state  <= S_FETCH;
        end
        S_FETCH: if (acc) begin
          if (err_ev) state <= S_IDLE;
          else begin
            case (widx)
              3'd0: d_next <= mem_rdata;
              3'd1: d_ctl  <= mem_rdata[1:0];
              3'd3: d_src  <= mem_rdata;
              3'd4: d_dst  <= mem_rdata;
              3'd5: d_size <= mem_rdata;
              default: ;
            endcase
            widx <= widx + 3'd1;
            if (widx == 3'd5) state <= (mem_rdata == 32'h0) ? S_WB : S_RD;
          end
        end
        S_RD: if (acc) begin
          if (mem_err) state <= S_IDLE;
          else begin
            hold  <= mem_rdata;
            state <= S_WR;
          end
        end
        S_WR: if (acc) begin
          if (mem_err) state <= S_IDLE;
          else begin
            d_src  <= d_src + 32'd4;
            d_dst  <= d_dst + 32'd4;
            d_size <= d_size - 32'd4;
            state  <= (d_size == 32'd4) ? S_WB : S_RD;
          end
        end
        S_WB: if (acc) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chen  <= '0;
      gflag <= '0;
      for (int c = 0; c < NCH; c++) begin
        cmdptr[c] <= '0;
        sema[c]   <= '0;
        cst[c]    <= '0;
      end
    end else begin
      if (reg_wr && reg_addr == A_MASK) chen <= reg_wdata[ENW-1:0];
      for (int c = 0; c < NCH; c++) begin
        logic [SEMW-1:0] add;
        add = wr_sem[c] ? reg_wdata[SEMW-1:0] : '0;

        if (wr_cmd[c]) cmdptr[c] <= reg_wdata;
        else if (done && own[c] && d_next != 32'h0) cmdptr[c] <= d_next;

        if (done && own[c]) begin
          if (d_next == 32'h0) sema[c] <= add;
          else sema[c] <= sema[c] + add - SEMW'(d_ctl[1]);
        end else begin
          sema[c] <= sema[c] + add;
        end

        if (err_ev && own[c]) cst[c] <= err_code;
        else if (wr_clr[c]) cst[c] <= cst[c] & ~reg_wdata[ERRW-1:0];

        if (own[c] && (err_ev || (done && d_ctl[0]))) gflag[c] <= 1'b1;
        else if (reg_wr && reg_addr == A_FCLR && reg_wdata[c]) gflag[c] <= 1'b0;
      end
    end
  end

  always_comb begin
    reg_rdata = 32'h0;
    if (reg_addr == A_FLAG) reg_rdata[NCH-1:0] = gflag;
    else if (reg_addr == A_MASK) reg_rdata[ENW-1:0] = chen;
    else if (in_grp) begin
      case (goff)
        6'h00: reg_rdata = cmdptr[gch];
        6'h10: reg_rdata[SEMW-1:0] = sema[gch];
        6'h20: reg_rdata[ERRW-1:0] = cst[gch];
        default: ;
      endcase
    end
  end
endmodule

module desc_copy_engine_chk #(
  parameter int SEMW = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            reg_wr,
  input logic [11:0]     reg_addr,
  input logic            mem_req,
  input logic            mem_we,
  input logic [31:0]     mem_addr,
  input logic            mem_ack,
  input logic            irq,
  input logic [SEMW-1:0] sema0
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R11

  AST_FLAG_FROM_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(mem_ack)); // R5

  AST_FLAG_CLEAR_ONLY_BY_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(reg_wr && reg_addr == 12'h018)); // R9

  AST_COUNT_DROP_AT_COMPLETION: assert property (@(posedge clk) disable iff (!rst_n)
    (sema0 < $past(sema0)) && !$past(reg_wr) |-> $past(mem_ack && mem_we)); // R6
endmodule

bind desc_copy_engine desc_copy_engine_chk #(.SEMW(SEMW)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_ack(mem_ack),
  .irq(irq), .sema0(sema[0])
);

// File: tb/desc_copy_engine_test.sv
module desc_copy_engine_test;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        reg_wr = 0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        m_ack = 0, m_err = 0;
  logic [31:0] m_rd = '0;
  logic        irq;

  int checks = 0, fails = 0;
  logic [31:0] mem [256];
  logic [31:0] flog [16];
  int nlog = 0, acts = 0, hold_bad = 0;
  logic        pend = 0;
  logic [31:0] pend_addr = '0;

  always #5 clk = ~clk;

  desc_copy_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(m_ack), .mem_rdata(m_rd), .mem_err(m_err), .irq(irq)
  );

  always @(posedge clk) begin
    if (!rst_n) begin
      m_ack <= 0;
      pend  <= 0;
    end else begin
      if (pend && (!mem_req || mem_addr != pend_addr)) hold_bad++;
      pend      <= mem_req && !m_ack;
      pend_addr <= mem_addr;
      if (mem_req) acts++;
      if (mem_req && m_ack && !mem_we && mem_addr < 32'h100 && mem_addr[4:0] == 5'd0 && nlog < 16) begin
        flog[nlog] = mem_addr;
        nlog++;
      end
      m_ack <= mem_req && !m_ack;
      if (mem_req && !m_ack) begin
        m_err <= (mem_addr >= 32'h400);
        m_rd  <= (mem_addr < 32'h400) ? mem[mem_addr[9:2]] : 32'h0;
        if (mem_we && mem_addr < 32'h400) mem[mem_addr[9:2]] = mem_wdata;
      end
    end
  end

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[15:0]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic do_reset();
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    @(negedge clk);
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    nlog = 0;
    acts = 0;
  endtask

  task automatic put_desc(input logic [31:0] b, input logic [31:0] nx, input logic [31:0] ctl,
                          input logic [31:0] s, input logic [31:0] d, input logic [31:0] sz);
    mem[b[9:2]]     = nx;
    mem[b[9:2] + 1] = ctl;
    mem[b[9:2] + 2] = 32'h0;
    mem[b[9:2] + 3] = s;
    mem[b[9:2] + 4] = d;
    mem[b[9:2] + 5] = sz;
    mem[b[9:2] + 6] = 32'h0;
    mem[b[9:2] + 7] = 32'hFFFF_FFFF;
    for (int i = 0; i < int'(sz / 4); i++) mem[s[9:2] + i] = pat(s + 32'(i * 4));
    for (int i = 0; i <= int'(sz / 4); i++) mem[d[9:2] + i] = 32'hDEAD_BEEF;
  endtask

  task automatic chk_copy(input string req, input logic [31:0] s, input logic [31:0] d, input logic [31:0] sz);
    for (int i = 0; i < int'(sz / 4); i++) chk(req, mem[d[9:2] + i], pat(s + 32'(i * 4)));
    chk(req, mem[d[9:2] + sz[9:2]], 32'hDEAD_BEEF);
  endtask

  task automatic wait_irq(input string req);
    bit ok;
    ok = 0;
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (irq) begin ok = 1; break; end
    end
    chk(req, 32'(ok), 32'd1);
  endtask

  localparam logic [95:0] VEC [4] = '{
    {32'd16, 32'h100, 32'h200},
    {32'd4,  32'h140, 32'h280},
    {32'd0,  32'h150, 32'h300},
    {32'd28, 32'h160, 32'h320}
  };

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    do_reset();

    // R1 reset state
    rd(12'h010, v); chk("R1 flags", v, 0);
    rd(12'h020, v); chk("R1 mask", v, 0);
    rd(12'h100, v); chk("R1 cmdptr", v, 0);
    rd(12'h150, v); chk("R1 sema", v, 0);
    rd(12'h1E0, v); chk("R1 status", v, 0);
    chk("R1 irq", 32'(irq), 0);
    chk("R1 mem_req", 32'(mem_req), 0);

    // R2 semaphore accumulates, pointer read back; R3 disabled channel idle
    wr(12'h150, 32'h0000_0102);
    wr(12'h150, 32'h0000_0003);
    rd(12'h150, v); chk("R2 sema add", v, 32'd5);
    wr(12'h1C0, 32'h1234_5670);
    rd(12'h1C0, v); chk("R2 cmdptr rw", v, 32'h1234_5670);
    repeat (50) @(negedge clk);
    chk("R3 disabled no access", 32'(acts), 0);

    // R4 R5 R6 table of copies on channel 0
    for (int t = 0; t < 4; t++) begin
      logic [31:0] sz, s, d;
      {sz, s, d} = VEC[t];
      do_reset();
      put_desc(32'h20, 32'h0, 32'h3, s, d, sz);
      wr(12'h100, 32'h20);
      wr(12'h110, 32'h1);
      wr(12'h020, 32'h1);
      wait_irq("R5 irq on completion");
      chk_copy("R4 copy", s, d, sz);
      chk("R5 status word", mem[8 + 7], 32'h0);
      rd(12'h010, v); chk("R5 flag bit", v, 32'h1);
      rd(12'h110, v); chk("R6 sema dec", v, 32'h0);
      rd(12'h120, v); chk("R8 no error", v, 32'h0);
      wr(12'h018, 32'h1);
      rd(12'h010, v); chk("R9 flag cleared", v, 32'h0);
      chk("R9 irq low", 32'(irq), 0);
    end

    // R5 no flag without bit0; R7 zero link clears count
    do_reset();
    put_desc(32'h20, 32'h0, 32'h0, 32'h100, 32'h200, 32'd8);
    wr(12'h180, 32'h20);
    wr(12'h190, 32'h2);
    wr(12'h020, 32'h4);
    repeat (200) @(negedge clk);
    chk_copy("R4 copy ch2", 32'h100, 32'h200, 32'd8);
    chk("R5 no irq without bit0", 32'(irq), 0);
    rd(12'h190, v); chk("R7 zero link clears count", v, 0);
    rd(12'h180, v); chk("R7 pointer kept", v, 32'h20);

    // R7 chain continues without decrement
    do_reset();
    put_desc(32'h20, 32'h40, 32'h0, 32'h100, 32'h200, 32'd8);
    put_desc(32'h40, 32'h0,  32'h3, 32'h120, 32'h240, 32'd12);
    wr(12'h140, 32'h20);
    wr(12'h150, 32'h1);
    wr(12'h020, 32'h2);
    wait_irq("R7 chain irq");
    chk_copy("R7 chain first", 32'h100, 32'h200, 32'd8);
    chk_copy("R7 chain second", 32'h120, 32'h240, 32'd12);
    rd(12'h140, v); chk("R7 pointer follows link", v, 32'h40);
    rd(12'h150, v); chk("R7 count end", v, 0);

    // R6 R7 chain halts when count reaches zero, resumes on increment
    do_reset();
    put_desc(32'h20, 32'h40, 32'h3, 32'h100, 32'h200, 32'd4);
    put_desc(32'h40, 32'h0,  32'h3, 32'h120, 32'h240, 32'd4);
    wr(12'h100, 32'h20);
    wr(12'h110, 32'h1);
    wr(12'h020, 32'h1);
    wait_irq("R6 first irq");
    repeat (100) @(negedge clk);
    chk_copy("R6 first done", 32'h100, 32'h200, 32'd4);
    chk("R6 second not run", mem[32'h240 >> 2], 32'hDEAD_BEEF);
    rd(12'h100, v); chk("R7 pointer at link", v, 32'h40);
    wr(12'h018, 32'h1);
    wr(12'h110, 32'h1);
    wait_irq("R7 resume irq");
    chk_copy("R7 resumed", 32'h120, 32'h240, 32'd4);

    // R8 misaligned size
    do_reset();
    put_desc(32'h20, 32'h0, 32'h0, 32'h100, 32'h200, 32'd6);
    wr(12'h1C0, 32'h20);
    wr(12'h1D0, 32'h1);
    wr(12'h020, 32'h8);
    wait_irq("R8 error irq despite bit0 clear");
    rd(12'h1E0, v); chk("R8 size code", v, 32'h2);
    rd(12'h010, v); chk("R8 flag", v, 32'h8);
    rd(12'h1D0, v); chk("R8 count kept", v, 32'h1);
    chk("R8 no status write", mem[8 + 7], 32'hFFFF_FFFF);
    chk("R8 no copy", mem[32'h200 >> 2], 32'hDEAD_BEEF);
    acts = 0;
    repeat (60) @(negedge clk);
    chk("R8 stopped", 32'(acts), 0);
    wr(12'h020, 32'h0);
    wr(12'h1E8, 32'h0000_0001);
    rd(12'h1E0, v); chk("R9 partial clear", v, 32'h2);
    wr(12'h1E8, 32'h0000_00FF);
    rd(12'h1E0, v); chk("R9 status cleared", v, 32'h0);
    wr(12'h018, 32'h1);
    rd(12'h010, v); chk("R9 other bit kept", v, 32'h8);

    // R8 memory error response
    do_reset();
    put_desc(32'h20, 32'h0, 32'h0, 32'h800, 32'h200, 32'd4);
    wr(12'h100, 32'h20);
    wr(12'h110, 32'h1);
    wr(12'h020, 32'h1);
    wait_irq("R8 bus error irq");
    rd(12'h120, v); chk("R8 bus code", v, 32'h1);
    chk("R8 bus no status write", mem[8 + 7], 32'hFFFF_FFFF);

    // R10 round-robin among three channels
    do_reset();
    for (int c = 0; c < 3; c++) begin
      logic [31:0] a, b;
      a = 32'h20 + 32'(c * 64);
      b = a + 32'h20;
      put_desc(a, b, 32'h0, 32'h100 + 32'(c * 16), 32'h200 + 32'(c * 32), 32'd4);
      put_desc(b, 32'h0, 32'h1, 32'h108 + 32'(c * 16), 32'h210 + 32'(c * 32), 32'd4);
      wr(12'h100 + 12'(c * 64), a);
      wr(12'h110 + 12'(c * 64), 32'h1);
    end
    wr(12'h020, 32'h7);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (nlog >= 6 && !mem_req) break;
    end
    rd(12'h010, v); chk("R10 all flags", v, 32'h7);
    chk("R10 fetch count", 32'(nlog), 32'd6);
    chk("R10 order 0", flog[0], 32'h20);
    chk("R10 order 1", flog[1], 32'h60);
    chk("R10 order 2", flog[2], 32'hA0);
    chk("R10 order 3", flog[3], 32'h40);
    chk("R10 order 4", flog[4], 32'h80);
    chk("R10 order 5", flog[5], 32'hC0);

    chk("R11 request held until ack", 32'(hold_bad), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule